// File: doc/BRIEF.md
# Output Amplitude Keying Ramp

This block shapes the amplitude envelope of a synthesized output so that it can be keyed on and off smoothly instead of with a hard edge. A keying pin, brought in through a two-stage synchronizer, sets the goal. In ramp mode the block moves a 14-bit amplitude toward the programmed target while the pin is high, and toward zero while it is low. The moves happen at a programmable tick rate and use one of four fixed increments. In direct mode the pin switches the output straight between zero and the target, with no ramp.

While enabled, the block raises an ownership flag. Downstream amplitude selection uses this flag to give the block precedence over every other amplitude source. The multiplication of the sine samples by this amplitude lies outside the block.

Top module: `amp_key_ramp`

## Requirements
- R1: While `enable` is low, `owns_amp` is low, and `amp_out` is 0 from the first clock edge after `enable` was sampled low.
- R2: While `enable` is high, `owns_amp` is high in both ramp mode and direct mode.
- R3: The keying pin passes through two synchronizing flip-flops. In direct mode a pin change first shows on `amp_out` on the third rising edge after it.
- R4: In direct mode (`auto_mode` = 0), `amp_out` is `target` when the synchronized pin is 1 and 0 when it is 0. No intermediate value appears.
- R5: In ramp mode a step happens once every 4*N clock cycles, where N = `rate_div`; a value of 0 is treated as 1. The first step lands on the 4*N-th rising edge after ramping starts.
- R6: `step_code` selects the increment: 1 gives 1 LSB, 2 gives 2 LSB, 3 gives 4 LSB, and 4 to 7 give 8 LSB.
- R7: In ramp mode with the pin high, `amp_out` rises toward `target` and stops exactly at `target` without overshoot.
- R8: In ramp mode with the pin low, `amp_out` falls toward 0 and stops at 0 without wrapping.
- R9: A `step_code` of 0 stops automatic ramping. `amp_out` then holds its value.
- R10: After reset, `amp_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; grants amplitude ownership |
| auto_mode | input | 1 | 1 = ramp mode, 0 = direct pin mode |
| key_pin | input | 1 | Asynchronous keying pin |
| target | input | 14 | Target amplitude |
| rate_div | input | 16 | Tick divider N (tick every 4*N clocks) |
| step_code | input | 3 | Step select; 0 stops ramping |
| amp_out | output | 14 | Current amplitude |
| owns_amp | output | 1 | Block holds amplitude control |

## Verification
The hardest case to reach is the saturation corner. The ramp must land exactly on the goal, and the last increment must be clipped because the remaining gap is smaller than the step. The stimulus uses targets that are not multiples of the step, for example a target of 20 with 8-LSB steps and then a fall back to zero. The exact amplitude is checked on each tick edge, counted from the enabling edge. Tick alignment is also checked at a nonunity divider and at a divider of zero.

// File: rtl/amp_key_ramp.sv
module amp_key_ramp #(
  parameter int AW = 14,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          auto_mode,
  input  logic          key_pin,
  input  logic [AW-1:0] target,
  input  logic [DW-1:0] rate_div,
  input  logic [2:0]    step_code,
  output logic [AW-1:0] amp_out,
  output logic          owns_amp
);
  localparam int CW = DW + 2;

  logic [1:0]    sync_q;
  logic          key_s;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;
  logic [DW-1:0] div_eff;
  logic          run;
  logic          tick;
  logic [AW-1:0] step_v;
  logic [AW-1:0] goal;
  logic [AW-1:0] amp_q;
  logic [AW-1:0] amp_nx;

  assign key_s   = sync_q[1];
  assign run     = enable && auto_mode && (step_code != 3'd0);
  assign div_eff = (rate_div == '0) ? DW'(1) : rate_div;
  assign lim     = {div_eff, 2'b00};
  assign tick    = run && (cnt_q == lim - CW'(1));
  assign goal    = key_s ? target : '0;

  always_comb begin
    case (step_code)
      3'd1:    step_v = AW'(1);
      3'd2:    step_v = AW'(2);
      3'd3:    step_v = AW'(4);
      default: step_v = AW'(8);
    endcase
  end

  always_comb begin
    amp_nx = amp_q;
    if (amp_q < goal)
      amp_nx = ((goal - amp_q) > step_v) ? amp_q + step_v : goal;
    else if (amp_q > goal)
      amp_nx = ((amp_q - goal) > step_v) ? amp_q - step_v : goal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], key_pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          amp_q <= '0;
    else if (!enable)    amp_q <= '0;
    else if (!auto_mode) amp_q <= goal;
    else if (tick)       amp_q <= amp_nx;
  end

  assign amp_out  = amp_q;
  assign owns_amp = enable;
endmodule

// File: rtl/amp_key_ramp_chk.sv
module amp_key_ramp_chk #(
  parameter int AW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          auto_mode,
  input logic          key_s,
  input logic [AW-1:0] target,
  input logic [2:0]    step_code,
  input logic [AW-1:0] amp_out
);
  a_r1_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!enable) |-> amp_out == '0);

  a_r4_direct_levels: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable && !auto_mode) && enable && !auto_mode)
      |-> (amp_out == '0 || amp_out == $past(target)));

  a_r6_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable && auto_mode) && enable && auto_mode)
      |-> ((amp_out >= $past(amp_out) ? amp_out - $past(amp_out)
                                      : $past(amp_out) - amp_out) <= AW'(8)));

  a_r7_no_overshoot: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable && auto_mode && key_s) && enable && auto_mode
      && amp_out > $past(amp_out)) |-> amp_out <= $past(target));

  a_r8_falls_only: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable && auto_mode && !key_s) && enable && auto_mode)
      |-> amp_out <= $past(amp_out));

  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable && auto_mode && step_code == 3'd0) && enable && auto_mode)
      |-> $stable(amp_out));

  a_r5_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable && auto_mode, 2) && $past(enable && auto_mode) && enable
      && auto_mode && amp_out != $past(amp_out))
      |-> $past(amp_out) == $past(amp_out, 2));
endmodule

bind amp_key_ramp amp_key_ramp_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .auto_mode(auto_mode),
  .key_s(key_s), .target(target), .step_code(step_code), .amp_out(amp_out)
);

// File: tb/sim_amp_key_ramp.sv
module sim_amp_key_ramp;
  localparam int CLK_P = 10;
  localparam int NV = 6;
  localparam int VK[NV] = '{1, 0, 1, 1, 0, 1};
  localparam int VT[NV] = '{100, 100, 16383, 7, 7, 0};
  localparam int VE[NV] = '{100, 0, 16383, 7, 0, 0};

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, auto_mode = 1'b0, key_pin = 1'b0;
  logic [13:0] target = '0;
  logic [15:0] rate_div = 16'd1;
  logic [2:0]  step_code = 3'd0;
  logic [13:0] amp_out;
  logic        owns_amp;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  amp_key_ramp u0 (.clk(clk), .rst_n(rst_n), .enable(enable), .auto_mode(auto_mode),
    .key_pin(key_pin), .target(target), .rate_div(rate_div), .step_code(step_code),
    .amp_out(amp_out), .owns_amp(owns_amp));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wn(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int held;
    wn(3);
    chk("R10 reset amp", amp_out, 0);
    chk("R1 owns low", owns_amp, 0);
    rst_n = 1'b1;
    wn(1);
    chk("R10 after reset", amp_out, 0);

    // direct mode vector table (R4, R2)
    enable = 1'b1; auto_mode = 1'b0;
    for (int i = 0; i < NV; i++) begin
      key_pin = VK[i][0]; target = VT[i][13:0];
      wn(4);
      chk("R4 direct level", amp_out, VE[i]);
      chk("R2 owns direct", owns_amp, 1);
    end

    // R3 synchronizer latency
    target = 14'd100; key_pin = 1'b0; wn(4);
    key_pin = 1'b1;
    wn(2); chk("R3 not yet", amp_out, 0);
    wn(1); chk("R3 third edge", amp_out, 100);

    // R1 disable
    enable = 1'b0;
    chk("R1 owns drops", owns_amp, 0);
    wn(1); chk("R1 amp zero", amp_out, 0);

    // ramp up with saturation: target 20, step 8, div 1
    auto_mode = 1'b1; target = 14'd20; rate_div = 16'd1; step_code = 3'd4;
    key_pin = 1'b1; wn(3);
    enable = 1'b1;
    chk("R2 owns auto", owns_amp, 1);
    wn(3); chk("R5 before tick", amp_out, 0);
    wn(1); chk("R6 step8 first", amp_out, 8);
    wn(4); chk("R7 second", amp_out, 16);
    wn(4); chk("R7 saturate", amp_out, 20);
    wn(4); chk("R7 hold", amp_out, 20);

    // ramp down
    key_pin = 1'b0;
    wn(40); chk("R8 falls to zero", amp_out, 0);

    // freeze
    key_pin = 1'b1; target = 14'd1000; wn(10);
    step_code = 3'd0; held = int'(amp_out);
    wn(20); chk("R9 frozen", amp_out, held);
    chk("R9 moved before freeze", int'(held > 0), 1);

    // divider 2, step 1
    enable = 1'b0; wn(1);
    rate_div = 16'd2; step_code = 3'd1; target = 14'd5;
    enable = 1'b1;
    wn(7);  chk("R5 div2 early", amp_out, 0);
    wn(1);  chk("R5 div2 tick", amp_out, 1);
    wn(8);  chk("R6 step1", amp_out, 2);

    // divider 0 treated as 1, step 2
    enable = 1'b0; wn(1);
    rate_div = 16'd0; step_code = 3'd2;
    enable = 1'b1;
    wn(3); chk("R5 div0 early", amp_out, 0);
    wn(1); chk("R6 step2", amp_out, 2);

    // step code 3
    enable = 1'b0; wn(1);
    rate_div = 16'd1; step_code = 3'd3; target = 14'd100;
    enable = 1'b1;
    wn(4); chk("R6 step4", amp_out, 4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule